// File: doc/BRIEF.md
# Instruction Cache with Partial Line Fills

This block is a direct-mapped instruction cache placed between a processor's fetch port and a memory port that returns one 32-bit word per request. Each line is four words. The stored tag for a line has two parts: the upper address bits, and a nibble with one invalid flag per word. When a cached fetch misses, the cache does not read the whole line. It reads memory from the missed word up to the last word of the line and marks only the skipped lower words invalid. Each fill reports a cost: the per-word access time multiplied by the number of words read.

A fetch is presented with `fetch_valid`, and the cache takes it in any cycle where `fetch_busy` is low. The answer appears as a one-cycle pulse on `rsp_valid`. A hit is answered in the cycle after the fetch is taken. On a miss, the requested word is forwarded one cycle after its memory response arrives. The cache then keeps `fetch_busy` high until the rest of the line is written. Fetches with `fetch_cached` low skip the cache and read one word from memory. Two maintenance commands are provided. A full-invalidate command sweeps every line, one line per cycle. A direct-write port stores a word into a line, as needed when the cache is isolated, and leaves the whole line marked invalid.

The controller has six states:
- INVAL sweeps the lines. It is also the reset state.
- IDLE serves hits and the two commands.
- FILL_REQ and FILL_WAIT issue and collect the fill words.
- BYP_REQ and BYP_WAIT handle one uncached read.

The transitions are:
- INVAL moves to IDLE after the last line is cleared.
- IDLE moves to INVAL on `inval_req`.
- IDLE moves to FILL_REQ on a cached miss, and to BYP_REQ on an uncached fetch.
- FILL_REQ and BYP_REQ move to their WAIT state when `mem_req_ready` is high.
- FILL_WAIT moves back to FILL_REQ after a response while words remain in the line, and to IDLE after the response for the last word.
- BYP_WAIT moves to IDLE on its response.

Top module: `icache_pfill`

## Requirements
- R1: After reset, the cache sweeps all LINES lines, one per cycle. `fetch_busy` stays high for exactly LINES cycles and no memory request is issued. After the sweep, every cached fetch misses.
- R2: A cached fetch at word offset i (address bits 3:2) hits only when both of these hold for the line selected by address bits [IDX_W+3:4]: the stored upper tag equals the fetch address above the index, and invalid bit i is clear. A hit produces `rsp_valid` with `rsp_hit`=1 in the cycle after acceptance, and no memory request.
- R3: A cached miss at word offset k issues one memory read per word, for words k up to 3 in ascending order. Each read address is the fetch address with bits 3:2 replaced by the word number and bits 1:0 set to zero. No word below k is read.
- R4: After a fill that started at offset k, the invalid nibble of the line is the k low bits set: 0x0, 0x1, 0x3 or 0x7. Fetches to words k..3 then hit and return the filled data. A fetch to a word below k misses.
- R5: On a miss, the requested word appears on `rsp_data` with `rsp_hit`=0, one cycle after its memory response. When k is less than 3, `fetch_busy` is still high at that point, and it stays high until the last word of the line is written.
- R6: `rsp_fill_cost` equals `word_cost` × (4 − k) on a miss response, with `word_cost` taken at acceptance. It is zero on a hit response and on an uncached response.
- R7: A full-invalidate command keeps `fetch_busy` high for LINES cycles and issues no memory request during the sweep. Afterwards every cached fetch misses.
- R8: A direct write stores `cwr_data` into the addressed line and word. It sets the line's upper tag from `cwr_addr` and all four invalid bits. Afterwards, cached fetches to any word of that line, including the written word, miss.
- R9: An uncached fetch issues exactly one memory read at its word address and returns that word with `rsp_hit`=0. It leaves the cache contents unchanged, so a line that hit before the uncached fetch still hits after it.
- R10: In IDLE, full invalidate takes priority over direct write, and direct write takes priority over a fetch. `fetch_busy` is high in any cycle where `inval_req` or `cwr_valid` is asserted, and a fetch presented in such a cycle is not taken.
- R11: A memory request holds `mem_req_valid` and `mem_req_addr` unchanged until `mem_req_ready` is seen. Only one request is outstanding at a time.
- R12: Two addresses that share an index but differ in their upper tag evict each other. After a fill of one, a fetch of the other misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_cached | input | 1 | Fetch comes from the cached address segment |
| fetch_busy | output | 1 | Fetch cannot be taken this cycle |
| rsp_valid | output | 1 | One-cycle pulse with the fetched word |
| rsp_data | output | DATA_W | Fetched instruction word |
| rsp_hit | output | 1 | Word was served from the cache |
| rsp_fill_cost | output | COST_W | Cycles charged for the fill |
| word_cost | input | COSTIN_W | Memory access time per word |
| inval_req | input | 1 | Full-invalidate command |
| cwr_valid | input | 1 | Direct cache write strobe |
| cwr_addr | input | ADDR_W | Direct write address |
| cwr_data | input | DATA_W | Direct write data |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DATA_W | Memory read data |

## Verification
The assertions assume the following about the memory side:
- It answers each accepted request with exactly one `mem_rsp_valid` pulse.
- It never raises `mem_rsp_valid` without an accepted request.
- It may delay `mem_req_ready` for any number of cycles.

The bench's responder models this directly. It stalls ready for zero to two cycles and waits zero or one cycle before responding, so the request-hold property is exercised.

The assertions also assume that `word_cost` is stable while a fetch is accepted, and that fetches, commands and data changes arrive only while `fetch_busy` is low. The bench drives stimulus only at falling edges after seeing `fetch_busy` low, and it changes the memory data tag only between fetches.

// File: rtl/icpf_pkg.sv
package icpf_pkg;

    // Controller states of the partial-fill instruction cache
    typedef enum logic [2:0] {
        ST_INVAL     = 3'd0,
        ST_IDLE      = 3'd1,
        ST_FILL_REQ  = 3'd2,
        ST_FILL_WAIT = 3'd3,
        ST_BYP_REQ   = 3'd4,
        ST_BYP_WAIT  = 3'd5
    } icpf_state_e;

endpackage

// File: rtl/icpf_tag_store.sv
module icpf_tag_store #(
    parameter int IDX_W      = 8,
    parameter int TAG_W      = 20,
    parameter int LINE_WORDS = 4,
    parameter int WOFF_W     = 2
) (
    input  logic                  clk,
    input  logic [IDX_W-1:0]      lk_idx,
    input  logic [TAG_W-1:0]      lk_tag,
    input  logic [WOFF_W-1:0]     lk_word,
    output logic                  lk_hit,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic [LINE_WORDS-1:0] wr_inv
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0]      tag_mem [LINES];
    logic [LINE_WORDS-1:0] inv_mem [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            inv_mem[wr_idx] <= wr_inv;
        end
    end

    // Upper address bits must agree and the selected word must not be flagged
    logic tag_eq;
    logic word_ok;
    assign tag_eq  = (tag_mem[lk_idx] == lk_tag);
    assign word_ok = ~inv_mem[lk_idx][lk_word];
    assign lk_hit  = tag_eq & word_ok;

endmodule

// File: rtl/icpf_data_store.sv
module icpf_data_store #(
    parameter int IDX_W      = 8,
    parameter int LINE_WORDS = 4,
    parameter int WOFF_W     = 2,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WOFF_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WOFF_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);
    localparam int LINES = 1 << IDX_W;

    logic [DATA_W-1:0] lane_rd [LINE_WORDS];

    // One storage lane per word position of a line
    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_lane
        logic [DATA_W-1:0] mem_q [LINES];

        always_ff @(posedge clk) begin
            if (clr_en) begin
                mem_q[clr_idx] <= '0;
            end else if (wr_en && (wr_word == WOFF_W'(g))) begin
                mem_q[wr_idx] <= wr_data;
            end
        end

        assign lane_rd[g] = mem_q[rd_idx];
    end

    assign rd_data = lane_rd[rd_word];

endmodule

// File: rtl/icpf_cost_calc.sv
module icpf_cost_calc #(
    parameter int LINE_WORDS = 4,
    parameter int WOFF_W     = 2,
    parameter int COSTIN_W   = 4,
    parameter int COST_W     = 7
) (
    input  logic [WOFF_W-1:0]   start_word,
    input  logic [COSTIN_W-1:0] word_cost,
    output logic [COST_W-1:0]   cost
);
    // Words fetched run from the start word to the end of the line
    logic [COST_W-1:0] nwords;
    assign nwords = COST_W'(LINE_WORDS) - COST_W'(start_word);
    assign cost   = COST_W'(word_cost) * nwords;

    // R6
    always_comb begin
        cost_bound_chk: assert (nwords >= COST_W'(1) && nwords <= COST_W'(LINE_WORDS))
            else $error("fill word count out of range");
    end

endmodule

// File: rtl/icache_pfill.sv
module icache_pfill
    import icpf_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CACHE_BYTES = 4096,
    parameter int LINE_WORDS  = 4,
    parameter int COSTIN_W    = 4,
    localparam int BYTE_OFF_W = $clog2(DATA_W / 8),
    localparam int WOFF_W     = $clog2(LINE_WORDS),
    localparam int LINES      = CACHE_BYTES / (LINE_WORDS * (DATA_W / 8)),
    localparam int IDX_W      = $clog2(LINES),
    localparam int TAG_W      = ADDR_W - IDX_W - WOFF_W - BYTE_OFF_W,
    localparam int COST_W     = COSTIN_W + WOFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_cached,
    output logic              fetch_busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_hit,
    output logic [COST_W-1:0] rsp_fill_cost,
    input  logic [COSTIN_W-1:0] word_cost,
    input  logic              inval_req,
    input  logic              cwr_valid,
    input  logic [ADDR_W-1:0] cwr_addr,
    input  logic [DATA_W-1:0] cwr_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int IDX_LO = BYTE_OFF_W + WOFF_W;
    localparam int TAG_LO = IDX_LO + IDX_W;

    // ---------------- address fields ----------------
    logic [TAG_W-1:0]  f_tag, c_tag;
    logic [IDX_W-1:0]  f_idx, c_idx;
    logic [WOFF_W-1:0] f_word, c_word;

    assign f_tag  = fetch_addr[TAG_LO +: TAG_W];
    assign f_idx  = fetch_addr[IDX_LO +: IDX_W];
    assign f_word = fetch_addr[BYTE_OFF_W +: WOFF_W];
    assign c_tag  = cwr_addr[TAG_LO +: TAG_W];
    assign c_idx  = cwr_addr[IDX_LO +: IDX_W];
    assign c_word = cwr_addr[BYTE_OFF_W +: WOFF_W];

    logic unused_low_bits;
    assign unused_low_bits = ^{fetch_addr[BYTE_OFF_W-1:0], cwr_addr[BYTE_OFF_W-1:0]};

    // ---------------- state and datapath registers ----------------
    icpf_state_e       state_q, state_d;
    logic [IDX_W-1:0]  sweep_q;
    logic [TAG_W-1:0]  req_tag_q;
    logic [IDX_W-1:0]  req_idx_q;
    logic [WOFF_W-1:0] req_k_q;
    logic [WOFF_W-1:0] cur_w_q;
    logic [COST_W-1:0] req_cost_q;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_data_q;
    logic              rsp_hit_q;
    logic [COST_W-1:0] rsp_cost_q;

    // ---------------- submodule wiring ----------------
    logic              lk_hit;
    logic [DATA_W-1:0] rd_data;
    logic [COST_W-1:0] miss_cost;

    logic                  tw_en;
    logic [IDX_W-1:0]      tw_idx;
    logic [TAG_W-1:0]      tw_tag;
    logic [LINE_WORDS-1:0] tw_inv;

    logic              dw_en;
    logic [IDX_W-1:0]  dw_idx;
    logic [WOFF_W-1:0] dw_word;
    logic [DATA_W-1:0] dw_data;
    logic              clr_en;

    icpf_tag_store #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_WORDS(LINE_WORDS), .WOFF_W(WOFF_W)
    ) u_tags (
        .clk(clk),
        .lk_idx(f_idx), .lk_tag(f_tag), .lk_word(f_word), .lk_hit(lk_hit),
        .wr_en(tw_en), .wr_idx(tw_idx), .wr_tag(tw_tag), .wr_inv(tw_inv)
    );

    icpf_data_store #(
        .IDX_W(IDX_W), .LINE_WORDS(LINE_WORDS), .WOFF_W(WOFF_W), .DATA_W(DATA_W)
    ) u_data (
        .clk(clk),
        .rd_idx(f_idx), .rd_word(f_word), .rd_data(rd_data),
        .wr_en(dw_en), .wr_idx(dw_idx), .wr_word(dw_word), .wr_data(dw_data),
        .clr_en(clr_en), .clr_idx(sweep_q)
    );

    icpf_cost_calc #(
        .LINE_WORDS(LINE_WORDS), .WOFF_W(WOFF_W), .COSTIN_W(COSTIN_W), .COST_W(COST_W)
    ) u_cost (
        .start_word(f_word), .word_cost(word_cost), .cost(miss_cost)
    );

    // ---------------- helpers ----------------
    function automatic logic [LINE_WORDS-1:0] below_mask(input logic [WOFF_W-1:0] k);
        logic [LINE_WORDS-1:0] m;
        for (int i = 0; i < LINE_WORDS; i++) begin
            m[i] = (i < int'(k));
        end
        return m;
    endfunction

    logic idle_free;
    logic accept;
    logic fill_last;
    logic sweep_last;

    assign idle_free  = (state_q == ST_IDLE) && !inval_req && !cwr_valid;
    assign accept     = idle_free && fetch_valid;
    assign fill_last  = (cur_w_q == WOFF_W'(LINE_WORDS - 1));
    assign sweep_last = (sweep_q == IDX_W'(LINES - 1));

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INVAL: begin
                if (sweep_last) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (inval_req) begin
                    state_d = ST_INVAL;
                end else if (cwr_valid) begin
                    state_d = ST_IDLE;
                end else if (fetch_valid) begin
                    if (!fetch_cached)  state_d = ST_BYP_REQ;
                    else if (!lk_hit)   state_d = ST_FILL_REQ;
                end
            end
            ST_FILL_REQ: begin
                if (mem_req_ready) state_d = ST_FILL_WAIT;
            end
            ST_FILL_WAIT: begin
                if (mem_rsp_valid) state_d = fill_last ? ST_IDLE : ST_FILL_REQ;
            end
            ST_BYP_REQ: begin
                if (mem_req_ready) state_d = ST_BYP_WAIT;
            end
            ST_BYP_WAIT: begin
                if (mem_rsp_valid) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INVAL;
        else        state_q <= state_d;
    end

    // ---------------- outputs and storage write controls ----------------
    always_comb begin
        fetch_busy    = !idle_free;
        mem_req_valid = 1'b0;
        mem_req_addr  = {req_tag_q, req_idx_q, cur_w_q, {BYTE_OFF_W{1'b0}}};
        tw_en   = 1'b0;
        tw_idx  = req_idx_q;
        tw_tag  = req_tag_q;
        tw_inv  = below_mask(req_k_q);
        dw_en   = 1'b0;
        dw_idx  = req_idx_q;
        dw_word = cur_w_q;
        dw_data = mem_rsp_data;
        clr_en  = 1'b0;
        unique case (state_q)
            ST_INVAL: begin
                tw_en  = 1'b1;
                tw_idx = sweep_q;
                tw_tag = '0;
                tw_inv = '1;
                clr_en = 1'b1;
            end
            ST_IDLE: begin
                if (!inval_req && cwr_valid) begin
                    tw_en   = 1'b1;
                    tw_idx  = c_idx;
                    tw_tag  = c_tag;
                    tw_inv  = '1;
                    dw_en   = 1'b1;
                    dw_idx  = c_idx;
                    dw_word = c_word;
                    dw_data = cwr_data;
                end
            end
            ST_FILL_REQ, ST_BYP_REQ: begin
                mem_req_valid = 1'b1;
            end
            ST_FILL_WAIT: begin
                if (mem_rsp_valid) begin
                    dw_en = 1'b1;
                    tw_en = fill_last;
                end
            end
            ST_BYP_WAIT: begin
            end
            default: begin
            end
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sweep_q     <= '0;
            req_tag_q   <= '0;
            req_idx_q   <= '0;
            req_k_q     <= '0;
            cur_w_q     <= '0;
            req_cost_q  <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            rsp_hit_q   <= 1'b0;
            rsp_cost_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (state_q == ST_INVAL) begin
                sweep_q <= sweep_q + IDX_W'(1);
            end else if (state_q == ST_IDLE && inval_req) begin
                sweep_q <= '0;
            end
            if (accept) begin
                req_tag_q  <= f_tag;
                req_idx_q  <= f_idx;
                req_k_q    <= f_word;
                cur_w_q    <= f_word;
                req_cost_q <= miss_cost;
                if (fetch_cached && lk_hit) begin
                    rsp_valid_q <= 1'b1;
                    rsp_data_q  <= rd_data;
                    rsp_hit_q   <= 1'b1;
                    rsp_cost_q  <= '0;
                end
            end
            if (state_q == ST_FILL_WAIT && mem_rsp_valid) begin
                if (cur_w_q == req_k_q) begin
                    rsp_valid_q <= 1'b1;
                    rsp_data_q  <= mem_rsp_data;
                    rsp_hit_q   <= 1'b0;
                    rsp_cost_q  <= req_cost_q;
                end
                if (!fill_last) cur_w_q <= cur_w_q + WOFF_W'(1);
            end
            if (state_q == ST_BYP_WAIT && mem_rsp_valid) begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= mem_rsp_data;
                rsp_hit_q   <= 1'b0;
                rsp_cost_q  <= '0;
            end
        end
    end

    assign rsp_valid     = rsp_valid_q;
    assign rsp_data      = rsp_data_q;
    assign rsp_hit       = rsp_hit_q;
    assign rsp_fill_cost = rsp_cost_q;

    // ---------------- assertions ----------------
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
        else $error("memory request dropped or changed before ready");

    // R3
    fill_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && state_q == ST_FILL_REQ) |->
            (mem_req_addr[BYTE_OFF_W +: WOFF_W] >= req_k_q))
        else $error("fill read below the missed word");

    // R6
    hit_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_fill_cost == '0))
        else $error("hit reported a fill cost");

    // R5
    miss_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> $past(mem_rsp_valid))
        else $error("miss response without a memory response");

    // R2
    hit_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> ($past(state_q) == ST_IDLE && !mem_req_valid))
        else $error("hit response outside idle or with memory traffic");

    // R7
    inval_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INVAL) |-> (fetch_busy && !mem_req_valid && !rsp_valid))
        else $error("activity during invalidate sweep");

endmodule

// File: tb/icache_pfill_tb.sv
`timescale 1ns/1ps
module icache_pfill_tb;
    localparam int LINES  = 16;
    localparam int CBYTES = LINES * 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_cached = 1'b0;
    logic        fetch_busy;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_hit;
    logic [6:0]  rsp_fill_cost;
    logic [3:0]  word_cost = 4'd1;
    logic        inval_req = 1'b0;
    logic        cwr_valid = 1'b0;
    logic [31:0] cwr_addr = '0;
    logic [31:0] cwr_data = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    always #4 clk = ~clk;

    icache_pfill #(.CACHE_BYTES(CBYTES)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_cached(fetch_cached),
        .fetch_busy(fetch_busy),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
        .rsp_fill_cost(rsp_fill_cost), .word_cost(word_cost),
        .inval_req(inval_req),
        .cwr_valid(cwr_valid), .cwr_addr(cwr_addr), .cwr_data(cwr_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] ep = 8'd1;
    int nreq = 0;
    int reqc = 0;
    logic [1:0]  req_words [16];
    logic [27:0] req_hi [16];
    logic [31:0] ma;
    logic        g_hit;
    logic [31:0] g_data;
    logic [6:0]  g_cost;
    logic        g_busy;

    function automatic logic [31:0] memf(input logic [31:0] a, input logic [7:0] e);
        return {e, a[23:0]} ^ 32'h1357_2468;
    endfunction

    function automatic logic [31:0] mk(input int tag, input int idx, input int w);
        return {tag[23:0], idx[3:0], w[1:0], 2'b00};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // memory model: variable ready stall and response latency
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (rst_n && mem_req_valid) begin
                ma = mem_req_addr;
                repeat (reqc % 3) @(negedge clk);
                mem_req_ready = 1'b1;
                if (nreq < 16) begin
                    req_words[nreq] = ma[3:2];
                    req_hi[nreq]    = ma[31:4];
                end
                nreq++;
                reqc++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (reqc % 2) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = memf(ma, ep);
            end
        end
    end

    task automatic do_fetch(input logic [31:0] a, input logic c);
        @(negedge clk);
        while (fetch_busy) @(negedge clk);
        nreq = 0;
        fetch_valid  = 1'b1;
        fetch_addr   = a;
        fetch_cached = c;
        @(negedge clk);
        fetch_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        g_hit  = rsp_hit;
        g_data = rsp_data;
        g_cost = rsp_fill_cost;
        g_busy = fetch_busy;
        while (fetch_busy) @(negedge clk);
    endtask

    task automatic expect_miss(input string req, input logic [31:0] a, input int wc);
        int k;
        k = int'(a[3:2]);
        chk(req, "miss hit flag", {31'd0, g_hit}, 32'd0);
        chk(req, "miss data", g_data, memf({a[31:2], 2'b00}, ep));
        chk("R6", "fill cost", {25'd0, g_cost}, 32'(wc * (4 - k)));
        chk("R3", "fill request count", 32'(nreq), 32'(4 - k));
        for (int j = 0; j < 4 - k; j++) begin
            chk("R3", "fill word order", {30'd0, req_words[j]}, 32'(k + j));
            chk("R3", "fill upper address", {4'd0, req_hi[j]}, {4'd0, a[31:4]});
        end
        chk("R5", "busy at miss response", {31'd0, g_busy}, {31'd0, (k < 3)});
    endtask

    task automatic expect_hit(input string req, input logic [31:0] a, input logic [7:0] e);
        chk(req, "hit flag", {31'd0, g_hit}, 32'd1);
        chk(req, "hit data", g_data, memf({a[31:2], 2'b00}, e));
        chk("R6", "hit cost", {25'd0, g_cost}, 32'd0);
        chk("R2", "hit memory reads", 32'(nreq), 32'd0);
    endtask

    task automatic do_inval(input logic [31:0] stray_addr);
        int n;
        @(negedge clk);
        while (fetch_busy) @(negedge clk);
        nreq = 0;
        inval_req    = 1'b1;
        fetch_valid  = 1'b1;
        fetch_addr   = stray_addr;
        fetch_cached = 1'b1;
        #1;
        chk("R10", "busy while invalidate asserted", {31'd0, fetch_busy}, 32'd1);
        @(negedge clk);
        inval_req   = 1'b0;
        fetch_valid = 1'b0;
        n = 0;
        while (fetch_busy) begin
            n++;
            @(negedge clk);
        end
        chk("R7", "invalidate busy cycles", 32'(n), 32'(LINES));
        chk("R7", "reads during invalidate", 32'(nreq), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [7:0]  fe;
        int n;
        int wc;

        // ---------- R1: reset sweep ----------
        repeat (3) @(negedge clk);
        chk("R1", "busy during reset", {31'd0, fetch_busy}, 32'd1);
        rst_n = 1'b1;
        n = 0;
        while (fetch_busy) begin
            n++;
            chk("R1", "no request during sweep", {31'd0, mem_req_valid}, 32'd0);
            @(negedge clk);
        end
        chk("R1", "reset sweep cycles", 32'(n), 32'(LINES));
        chk("R1", "no response after reset", {31'd0, rsp_valid}, 32'd0);

        // ---------- R2 R3 R4 R5 R6: sweep every line and start word ----------
        for (int idx = 0; idx < LINES; idx++) begin
            for (int k = 0; k < 4; k++) begin
                int t;
                t  = 16 + idx * 4 + k;
                wc = ((idx + k) % 15) + 1;
                word_cost = 4'(wc);
                a = mk(t, idx, k);
                ep = ep + 8'd1;
                do_fetch(a, 1'b1);
                if (idx == 0 && k == 0) expect_miss("R1", a, wc);
                else                    expect_miss("R3", a, wc);
                fe = ep;
                ep = ep + 8'd1;
                for (int w = k; w < 4; w++) begin
                    do_fetch(mk(t, idx, w), 1'b1);
                    expect_hit("R4", mk(t, idx, w), fe);
                end
                if (k > 0) begin
                    a = mk(t, idx, k - 1);
                    do_fetch(a, 1'b1);
                    expect_miss("R4", a, wc);
                end
            end
        end

        // ---------- R12: eviction by a conflicting tag ----------
        word_cost = 4'd3;
        ep = ep + 8'd1;
        do_fetch(mk(900, 3, 0), 1'b1);
        expect_miss("R12", mk(900, 3, 0), 3);
        ep = ep + 8'd1;
        do_fetch(mk(901, 3, 0), 1'b1);
        expect_miss("R12", mk(901, 3, 0), 3);
        ep = ep + 8'd1;
        do_fetch(mk(900, 3, 2), 1'b1);
        expect_miss("R12", mk(900, 3, 2), 3);

        // ---------- R9: uncached fetches ----------
        ep = ep + 8'd1;
        do_fetch(mk(950, 5, 0), 1'b1);
        expect_miss("R9", mk(950, 5, 0), 3);
        fe = ep;
        ep = ep + 8'd1;
        do_fetch(mk(951, 5, 1), 1'b0);
        chk("R9", "uncached hit flag", {31'd0, g_hit}, 32'd0);
        chk("R9", "uncached data", g_data, memf(mk(951, 5, 1), ep));
        chk("R9", "uncached read count", 32'(nreq), 32'd1);
        chk("R9", "uncached read word", {30'd0, req_words[0]}, 32'd1);
        chk("R6", "uncached cost", {25'd0, g_cost}, 32'd0);
        do_fetch(mk(950, 5, 2), 1'b0);
        chk("R9", "uncached same address reads memory", 32'(nreq), 32'd1);
        chk("R9", "uncached same address hit flag", {31'd0, g_hit}, 32'd0);
        do_fetch(mk(950, 5, 1), 1'b1);
        expect_hit("R9", mk(950, 5, 1), fe);

        // ---------- R8 R10: direct write ----------
        ep = ep + 8'd1;
        do_fetch(mk(960, 7, 0), 1'b1);
        expect_miss("R8", mk(960, 7, 0), 3);
        fe = ep;
        do_fetch(mk(960, 7, 1), 1'b1);
        expect_hit("R8", mk(960, 7, 1), fe);
        @(negedge clk);
        while (fetch_busy) @(negedge clk);
        nreq = 0;
        cwr_valid    = 1'b1;
        cwr_addr     = mk(960, 7, 1);
        cwr_data     = 32'hCAFE_0001;
        fetch_valid  = 1'b1;
        fetch_addr   = mk(960, 7, 3);
        fetch_cached = 1'b1;
        #1;
        chk("R10", "busy while direct write asserted", {31'd0, fetch_busy}, 32'd1);
        @(negedge clk);
        cwr_valid   = 1'b0;
        fetch_valid = 1'b0;
        chk("R10", "fetch not taken during write", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk("R10", "no read after refused fetch", {31'd0, mem_req_valid}, 32'd0);
        ep = ep + 8'd1;
        do_fetch(mk(960, 7, 1), 1'b1);
        expect_miss("R8", mk(960, 7, 1), 3);
        ep = ep + 8'd1;
        do_fetch(mk(960, 7, 0), 1'b1);
        expect_miss("R8", mk(960, 7, 0), 3);

        // ---------- R7 R10: full invalidate ----------
        ep = ep + 8'd1;
        do_fetch(mk(970, 9, 0), 1'b1);
        expect_miss("R7", mk(970, 9, 0), 3);
        do_fetch(mk(971, 10, 0), 1'b1);
        expect_miss("R7", mk(971, 10, 0), 3);
        do_inval(mk(970, 9, 1));
        chk("R10", "stray fetch not answered", {31'd0, rsp_valid}, 32'd0);
        for (int w = 0; w < 4; w++) begin
            ep = ep + 8'd1;
            do_fetch(mk(970 + w, 9 + (w % 2), 3), 1'b1);
            chk("R7", "miss after invalidate", {31'd0, g_hit}, 32'd0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule